// File: doc/BRIEF.md
# Counter Target and Range Comparator

This block watches the present value of a 32-bit counter and compares it every clock cycle against two programmable tables. The target table has up to 48 entries. Each entry holds an enable, a 32-bit value and an 8-bit interrupt identifier. When the count lands on an entry's value, the block raises an interrupt event that carries that identifier. The range table holds up to 32 windows. Each window has its own lower limit, upper limit and identifier. The block drives one status bit per window, and that bit is high while the count sits inside the window.

The block does not implement the counter itself. It receives the count, a strobe that marks a counter clear, and a policy bit. The policy bit decides what a clear does. Either comparison continues as if nothing happened, or comparison halts until an explicit start command arrives. A configuration input limits the range table to its first 8 windows or opens all 32. Software fills both tables through simple write ports.

Top module: `count_compare_unit`

## Requirements
- R1: After synchronous reset, every table entry is disabled, `irq_valid_o` is 0, `rng_hit_o` is all zeros, `rng_any_o` is 0 and `active_o` is 1.
- R2: A target write with `tgt_we_i` high stores enable, value and identifier at `tgt_addr_i`. Addresses of 48 or above are ignored. The new entry takes part in comparison from the cycle after the write.
- R3: When the count first equals an enabled target, a single event appears on the next cycle: `irq_valid_o` high, with `irq_idx_o` and `irq_id_o` naming the entry. While the count stays equal, no further event is raised. If the count moves away and comes back, a new event is raised.
- R4: Targets that match in the same cycle are reported one per cycle, in ascending index order. None is lost.
- R5: `rng_hit_o[i]` is 1 one cycle after a count that satisfies lo ≤ count ≤ hi (unsigned, both limits included) for an enabled window i. `rng_any_o` is the OR of those bits. `rng_id_o` is the identifier of the lowest-numbered window that hits.
- R6: A window whose lower limit is greater than its upper limit never hits.
- R7: With `range_wide_i` = 0, only windows 0 to 7 are compared and bits 8 to 31 of `rng_hit_o` stay 0. With `range_wide_i` = 1, all 32 windows are compared.
- R8: A `cnt_clear_i` pulse while `halt_on_clear_i` = 1 drops `active_o` on the next cycle. While halted, no target event is raised, queued events are discarded and `rng_hit_o` is all zeros.
- R9: A `cnt_clear_i` pulse while `halt_on_clear_i` = 0 has no effect on comparison. `active_o`, range bits and target events carry on unchanged.
- R10: A `start_i` pulse while halted sets `active_o` on the next cycle, and a target equal to the count at that point is then reported. If `start_i` and a halting clear arrive in the same cycle, the clear wins.
- R11: A disabled target entry never raises an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_i | input | 32 | Present counter value |
| cnt_clear_i | input | 1 | Strobe: the counter was cleared this cycle |
| halt_on_clear_i | input | 1 | Policy: 1 halts comparison on a clear, 0 continues |
| start_i | input | 1 | Resume comparison after a halt |
| range_wide_i | input | 1 | 0 compares windows 0..7, 1 compares windows 0..31 |
| tgt_we_i | input | 1 | Target table write enable |
| tgt_addr_i | input | 6 | Target entry index |
| tgt_en_i | input | 1 | Enable bit to store |
| tgt_value_i | input | 32 | Target count to store |
| tgt_id_i | input | 8 | Interrupt identifier to store |
| rng_we_i | input | 1 | Range table write enable |
| rng_addr_i | input | 5 | Window index |
| rng_en_i | input | 1 | Enable bit to store |
| rng_lo_i | input | 32 | Lower limit to store |
| rng_hi_i | input | 32 | Upper limit to store |
| rng_id_i | input | 8 | Window identifier to store |
| active_o | output | 1 | Comparison running |
| irq_valid_o | output | 1 | Target event this cycle |
| irq_idx_o | output | 6 | Index of the reported target |
| irq_id_o | output | 8 | Identifier of the reported target |
| rng_hit_o | output | 32 | One bit per window: count inside the window |
| rng_any_o | output | 1 | Any window hit |
| rng_id_o | output | 8 | Identifier of the lowest window that hit |

## Verification
A corrupt edge-detect or pending bit appears at the ports within one or two cycles. It shows up as a repeated, missing or out-of-order event against the scoreboard's expected sequence, which is exercised with three simultaneous matches and with a count that leaves a target and returns to it. A wrong run state shows at once on `active_o`, and on the next cycle as range bits or events that should be quiet. A stale or misplaced table entry shows as wrong identifiers or wrong hit bits at the window limits, one cycle after the count is applied.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

    localparam int CNT_W = 32;
    localparam int ID_W  = 8;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [ID_W-1:0]  irq_id_t;

    typedef struct packed {
        logic    en;
        count_t  value;
        irq_id_t id;
    } tgt_entry_t;

    typedef struct packed {
        logic    en;
        count_t  lo;
        count_t  hi;
        irq_id_t id;
    } rng_entry_t;

    typedef enum logic {
        CMP_RUN  = 1'b0,
        CMP_HALT = 1'b1
    } run_state_t;

    // inclusive window test, unsigned
    function automatic logic in_window(count_t v, count_t lo, count_t hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/cmpu_run_ctrl.sv
module cmpu_run_ctrl
    import cmpu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cnt_clear_i,
    input  logic halt_on_clear_i,
    input  logic start_i,
    output logic active_o
);

    run_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cnt_clear_i && halt_on_clear_i)
            state_d = CMP_HALT;          // clear wins over start
        else if (start_i)
            state_d = CMP_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CMP_RUN;
        else     state_q <= state_d;
    end

    assign active_o = (state_q == CMP_RUN);

    a_r8_halt_on_clear: assert property (@(posedge clk) disable iff (rst)
        (cnt_clear_i && halt_on_clear_i) |=> !active_o);

    a_r10_start_resumes: assert property (@(posedge clk) disable iff (rst)
        (start_i && !cnt_clear_i) |=> active_o);

    a_r9_clear_ignored: assert property (@(posedge clk) disable iff (rst)
        (active_o && cnt_clear_i && !halt_on_clear_i) |=> active_o);

endmodule

// File: rtl/cmpu_target_bank.sv
module cmpu_target_bank
    import cmpu_pkg::*;
#(
    parameter int NUM_TGT = 48,
    parameter int TIW     = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           active_i,
    input  count_t         count_i,
    input  logic           we_i,
    input  logic [TIW-1:0] addr_i,
    input  tgt_entry_t     wdata_i,
    output logic           irq_valid_o,
    output logic [TIW-1:0] irq_idx_o,
    output irq_id_t        irq_id_o
);

    tgt_entry_t         tbl_q [NUM_TGT];
    logic [NUM_TGT-1:0] prev_q, pend_q;
    logic [NUM_TGT-1:0] eq, fresh, cand, grant;
    logic               found;
    logic [TIW-1:0]     sel;
    logic               addr_ok;

    assign addr_ok = (int'(addr_i) < NUM_TGT);

    // per-entry equality and first-match detection
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_cmp
        assign eq[g]    = active_i && tbl_q[g].en && (tbl_q[g].value == count_i);
        assign fresh[g] = eq[g] && !prev_q[g];
        assign cand[g]  = active_i && (pend_q[g] || fresh[g]);
    end

    // lowest index wins; the rest stay pending
    always_comb begin
        found = 1'b0;
        sel   = '0;
        grant = '0;
        for (int i = NUM_TGT - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found    = 1'b1;
                sel      = TIW'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TGT; i++) tbl_q[i] <= '0;
            prev_q      <= '0;
            pend_q      <= '0;
            irq_valid_o <= 1'b0;
            irq_idx_o   <= '0;
            irq_id_o    <= '0;
        end else begin
            if (we_i && addr_ok) tbl_q[addr_i] <= wdata_i;
            prev_q      <= eq;
            pend_q      <= cand & ~grant;
            irq_valid_o <= found;
            irq_idx_o   <= sel;
            irq_id_o    <= tbl_q[sel].id;
        end
    end

    a_r3_idx_in_table: assert property (@(posedge clk) disable iff (rst)
        irq_valid_o |-> (int'(irq_idx_o) < NUM_TGT));

    a_r8_no_event_halted: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> !irq_valid_o);

    a_r8_pending_flushed: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> (pend_q == '0));

endmodule

// File: rtl/cmpu_range_bank.sv
module cmpu_range_bank
    import cmpu_pkg::*;
#(
    parameter int RNG_MAX   = 32,
    parameter int RNG_SMALL = 8,
    parameter int RIW       = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active_i,
    input  logic               wide_i,
    input  count_t             count_i,
    input  logic               we_i,
    input  logic [RIW-1:0]     addr_i,
    input  rng_entry_t         wdata_i,
    output logic [RNG_MAX-1:0] rng_hit_o,
    output logic               rng_any_o,
    output irq_id_t            rng_id_o
);

    rng_entry_t         tbl_q [RNG_MAX];
    logic [RNG_MAX-1:0] hit;
    irq_id_t            first_id;

    for (genvar g = 0; g < RNG_MAX; g++) begin : g_win
        logic in_scope;
        if (g < RNG_SMALL) begin : g_base
            assign in_scope = 1'b1;
        end else begin : g_ext
            assign in_scope = wide_i;
        end
        assign hit[g] = active_i && in_scope && tbl_q[g].en
                        && in_window(count_i, tbl_q[g].lo, tbl_q[g].hi);

        a_r6_inverted_quiet: assert property (@(posedge clk) disable iff (rst)
            rng_hit_o[g] |-> $past(tbl_q[g].lo <= tbl_q[g].hi));
    end

    always_comb begin
        first_id = '0;
        for (int i = RNG_MAX - 1; i >= 0; i--)
            if (hit[i]) first_id = tbl_q[i].id;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RNG_MAX; i++) tbl_q[i] <= '0;
            rng_hit_o <= '0;
            rng_any_o <= 1'b0;
            rng_id_o  <= '0;
        end else begin
            if (we_i) tbl_q[addr_i] <= wdata_i;
            rng_hit_o <= hit;
            rng_any_o <= |hit;
            rng_id_o  <= first_id;
        end
    end

    a_r7_narrow_table: assert property (@(posedge clk) disable iff (rst)
        !$past(wide_i) |-> (rng_hit_o[RNG_MAX-1:RNG_SMALL] == '0));

    a_r8_ranges_quiet: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> (rng_hit_o == '0 && !rng_any_o));

endmodule

// File: rtl/count_compare_unit.sv
module count_compare_unit
    import cmpu_pkg::*;
#(
    parameter int NUM_TGT   = 48,
    parameter int RNG_MAX   = 32,
    parameter int RNG_SMALL = 8,
    localparam int TIW = $clog2(NUM_TGT),
    localparam int RIW = $clog2(RNG_MAX)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               cnt_clear_i,
    input  logic               halt_on_clear_i,
    input  logic               start_i,
    input  logic               range_wide_i,
    input  logic               tgt_we_i,
    input  logic [TIW-1:0]     tgt_addr_i,
    input  logic               tgt_en_i,
    input  logic [CNT_W-1:0]   tgt_value_i,
    input  logic [ID_W-1:0]    tgt_id_i,
    input  logic               rng_we_i,
    input  logic [RIW-1:0]     rng_addr_i,
    input  logic               rng_en_i,
    input  logic [CNT_W-1:0]   rng_lo_i,
    input  logic [CNT_W-1:0]   rng_hi_i,
    input  logic [ID_W-1:0]    rng_id_i,
    output logic               active_o,
    output logic               irq_valid_o,
    output logic [TIW-1:0]     irq_idx_o,
    output logic [ID_W-1:0]    irq_id_o,
    output logic [RNG_MAX-1:0] rng_hit_o,
    output logic               rng_any_o,
    output logic [ID_W-1:0]    rng_id_o
);

    tgt_entry_t tgt_wdata;
    rng_entry_t rng_wdata;

    assign tgt_wdata = '{en: tgt_en_i, value: tgt_value_i, id: tgt_id_i};
    assign rng_wdata = '{en: rng_en_i, lo: rng_lo_i, hi: rng_hi_i, id: rng_id_i};

    cmpu_run_ctrl u_run (
        .clk             (clk),
        .rst             (rst),
        .cnt_clear_i     (cnt_clear_i),
        .halt_on_clear_i (halt_on_clear_i),
        .start_i         (start_i),
        .active_o        (active_o)
    );

    cmpu_target_bank #(
        .NUM_TGT (NUM_TGT),
        .TIW     (TIW)
    ) u_tgt (
        .clk         (clk),
        .rst         (rst),
        .active_i    (active_o),
        .count_i     (count_i),
        .we_i        (tgt_we_i),
        .addr_i      (tgt_addr_i),
        .wdata_i     (tgt_wdata),
        .irq_valid_o (irq_valid_o),
        .irq_idx_o   (irq_idx_o),
        .irq_id_o    (irq_id_o)
    );

    cmpu_range_bank #(
        .RNG_MAX   (RNG_MAX),
        .RNG_SMALL (RNG_SMALL),
        .RIW       (RIW)
    ) u_rng (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active_o),
        .wide_i    (range_wide_i),
        .count_i   (count_i),
        .we_i      (rng_we_i),
        .addr_i    (rng_addr_i),
        .wdata_i   (rng_wdata),
        .rng_hit_o (rng_hit_o),
        .rng_any_o (rng_any_o),
        .rng_id_o  (rng_id_o)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!irq_valid_o && rng_hit_o == '0 && active_o));

endmodule

// File: tb/count_compare_unit_test.sv
module count_compare_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] count_i = 32'hFFFF_0000;
    logic        cnt_clear_i = 0, halt_on_clear_i = 0, start_i = 0, range_wide_i = 0;
    logic        tgt_we_i = 0, tgt_en_i = 0;
    logic [5:0]  tgt_addr_i = '0;
    logic [31:0] tgt_value_i = '0;
    logic [7:0]  tgt_id_i = '0;
    logic        rng_we_i = 0, rng_en_i = 0;
    logic [4:0]  rng_addr_i = '0;
    logic [31:0] rng_lo_i = '0, rng_hi_i = '0;
    logic [7:0]  rng_id_i = '0;
    logic        active_o, irq_valid_o, rng_any_o;
    logic [5:0]  irq_idx_o;
    logic [7:0]  irq_id_o, rng_id_o;
    logic [31:0] rng_hit_o;

    int n_chk = 0, n_fail = 0;
    logic [13:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    count_compare_unit uut (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_tgt(int a, logic en, logic [31:0] v, logic [7:0] id);
        @(posedge clk); #1;
        tgt_we_i = 1; tgt_addr_i = 6'(a); tgt_en_i = en; tgt_value_i = v; tgt_id_i = id;
        @(posedge clk); #1;
        tgt_we_i = 0;
    endtask

    task automatic wr_rng(int a, logic [31:0] lo, logic [31:0] hi, logic [7:0] id);
        @(posedge clk); #1;
        rng_we_i = 1; rng_addr_i = 5'(a); rng_en_i = 1; rng_lo_i = lo; rng_hi_i = hi; rng_id_i = id;
        @(posedge clk); #1;
        rng_we_i = 0;
    endtask

    task automatic expect_irq(int idx, logic [7:0] id, string tag);
        exp_q.push_back({6'(idx), id});
        tag_q.push_back(tag);
    endtask

    // drive a count, then sample ranges after the registering edge
    task automatic range_at(logic [31:0] v, logic [31:0] hit, logic [7:0] id, string tag);
        @(posedge clk); #1;
        count_i = v;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " hit"}, 64'(rng_hit_o), 64'(hit));
        chk({tag, " any"}, 64'(rng_any_o), 64'(hit != 0));
        if (hit != 0) chk({tag, " id"}, 64'(rng_id_o), 64'(id));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && irq_valid_o) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3 unexpected event actual=%0h/%0h expected=none",
                         irq_idx_o, irq_id_o);
            end else begin
                logic [13:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({irq_idx_o, irq_id_o} !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%0h expected=%0h", t, {irq_idx_o, irq_id_o}, e);
                end
            end
        end
    end

    initial begin
        repeat (400000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 0;
        @(negedge clk);
        chk("R1 irq_valid", 64'(irq_valid_o), 0);
        chk("R1 rng_hit", 64'(rng_hit_o), 0);
        chk("R1 active", 64'(active_o), 1);

        // target table (R2, R11)
        wr_tgt(5, 1, 100, 8'h15);
        wr_tgt(2, 1, 100, 8'h12);
        wr_tgt(40, 1, 100, 8'h40);
        wr_tgt(7, 1, 200, 8'h77);
        wr_tgt(47, 1, 300, 8'hAB);
        wr_tgt(10, 0, 400, 8'h99);
        wr_tgt(50, 1, 500, 8'hEE);  // out of range address, ignored (R2)

        // R4: three simultaneous matches, ascending order; R3: held count no repeat
        expect_irq(2, 8'h12, "R4 first");
        expect_irq(5, 8'h15, "R4 second");
        expect_irq(40, 8'h40, "R4 third");
        @(posedge clk); #1; count_i = 100;
        cyc(8);
        chk("R3 held count drained", 64'(exp_q.size()), 0);

        // R3: leave and return
        expect_irq(7, 8'h77, "R3 first hit");
        count_i = 200; cyc(3);
        count_i = 201; cyc(2);
        expect_irq(7, 8'h77, "R3 rehit");
        count_i = 200; cyc(4);
        expect_irq(47, 8'hAB, "R2 last index");
        count_i = 300; cyc(4);
        count_i = 400; cyc(4);   // R11 disabled entry
        count_i = 500; cyc(4);   // R2 ignored address
        chk("R11 R2 no stray events", 64'(exp_q.size()), 0);

        // ranges
        wr_rng(0, 1000, 2000, 8'h21);
        wr_rng(3, 1500, 1500, 8'h23);
        wr_rng(6, 3000, 2000, 8'h26);
        wr_rng(20, 0, 5000, 8'h50);
        range_at(1000, 32'h1, 8'h21, "R5 low limit");
        range_at(2000, 32'h1, 8'h21, "R5 high limit");
        range_at(1500, 32'h9, 8'h21, "R5 overlap");
        range_at(2001, 32'h0, 8'h00, "R7 narrow excludes 20");
        range_at(2500, 32'h0, 8'h00, "R6 inverted");
        @(posedge clk); #1; range_wide_i = 1;
        range_at(2500, 32'h0010_0000, 8'h50, "R7 wide");
        range_at(999, 32'h0010_0000, 8'h50, "R7 wide low");

        // R9: clear ignored under continue policy
        @(posedge clk); #1; halt_on_clear_i = 0; cnt_clear_i = 1;
        @(posedge clk); #1; cnt_clear_i = 0;
        @(posedge clk); @(negedge clk);
        chk("R9 active", 64'(active_o), 1);
        chk("R9 ranges", 64'(rng_hit_o), 64'h0010_0000);
        expect_irq(2, 8'h12, "R9 events");
        expect_irq(5, 8'h15, "R9 events");
        expect_irq(40, 8'h40, "R9 events");
        @(posedge clk); #1; count_i = 100;
        cyc(6);
        chk("R9 drained", 64'(exp_q.size()), 0);

        // R8: halting clear
        count_i = 5000; halt_on_clear_i = 1; cnt_clear_i = 1;
        @(posedge clk); #1; cnt_clear_i = 0;
        @(posedge clk); @(negedge clk);
        chk("R8 active", 64'(active_o), 0);
        chk("R8 ranges", 64'(rng_hit_o), 0);
        @(posedge clk); #1; count_i = 100;
        cyc(5);
        chk("R8 no events", 64'(irq_valid_o), 0);

        // R10: clear beats start
        start_i = 1; cnt_clear_i = 1;
        @(posedge clk); #1; start_i = 0; cnt_clear_i = 0;
        @(negedge clk);
        chk("R10 clear wins", 64'(active_o), 0);

        // R10: start resumes, match present fires
        expect_irq(2, 8'h12, "R10 resume");
        expect_irq(5, 8'h15, "R10 resume");
        expect_irq(40, 8'h40, "R10 resume");
        @(posedge clk); #1; start_i = 1;
        @(posedge clk); #1; start_i = 0;
        @(negedge clk);
        chk("R10 active", 64'(active_o), 1);
        cyc(6);
        chk("R10 drained", 64'(exp_q.size()), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule